// File: doc/BRIEF.md
# Four-Lane Multiply-Sum Accumulator

This block is a pipelined convolution datapath for pixel interpolation and FIR filtering. On every clock it accepts four signed data samples and four signed coefficients and multiplies them lane by lane. It adds the four products together and either adds that total to a wide running accumulator or starts the accumulator afresh with it. A 16-bit window of the accumulator is presented on a registered output.

Each lane has one enable. A shared select steers that enable to either the data register or the coefficient register of the lane, and the other register of the lane loads on every clock. This lets a filter keep its coefficients, or a mixer keep its pixels, across many cycles. A format select chooses between integer and fractional two's complement. The format decides which 16 bits are shown and whether a half-LSB rounding term is folded in.

Top module: `mac4_array`

## Requirements
- R1: While rst_ni is low, sum_o, every operand register, the accumulator and all pipeline registers are zero. A lane whose register is held from reset onward contributes a zero operand.
- R2: Each lane multiplies a signed 10-bit data word (lane i on data_i[10i+9:10i]) by a signed 11-bit coefficient (lane i on coef_i[11i+10:11i]). The four products are summed with full precision.
- R3: Operands and controls (accum_i, frac_i) presented before clock edge n affect sum_o right after edge n+4. That is five register stages from the pins to the port.
- R4: When sel_coef_i is 0, lane_en_i[i] gates the data register of lane i and the coefficient register loads every clock. When sel_coef_i is 1, lane_en_i[i] gates the coefficient register and the data register loads every clock. A gated register keeps its value while its enable is 0.
- R5: When accum_i is 1, the new four-product sum is added to the accumulator contents. When accum_i is 0, the accumulator is loaded with the new sum alone.
- R6: When frac_i is 0 (integer format), sum_o shows accumulator bits 15:0 and no rounding term is added.
- R7: When frac_i is 1 (fractional format), sum_o shows accumulator bits 24:9. A fresh load (accum_i 0) adds 256, which is half of an output LSB, exactly once.
- R8: The accumulator is 25 bits wide and wraps modulo 2^25. It never saturates.
- R9: When out_en_i is 0 at a clock edge, sum_o keeps its previous value. The pipeline behind it keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 40 | Four signed 10-bit data words, lane 0 in the low bits |
| coef_i | input | 44 | Four signed 11-bit coefficients, lane 0 in the low bits |
| lane_en_i | input | 4 | Per-lane load enable for the selected operand register |
| sel_coef_i | input | 1 | 0: enables gate data registers; 1: enables gate coefficient registers |
| accum_i | input | 1 | 1: add to the accumulator; 0: load it fresh |
| frac_i | input | 1 | 1: fractional format; 0: integer format |
| out_en_i | input | 1 | Output register load enable |
| sum_o | output | 16 | Selected accumulator window |

## Verification
The hardest case to reach from the ports is accumulator wrap beyond 25 bits. Random operands almost never push the total past the headroom. The bench therefore drives every lane with the most negative data and the most negative coefficient, which gives the largest positive product. It then holds accum_i high in fractional format until the top bits visibly wrap. Held operand registers are reached by driving random enable masks under both select values while the free operand keeps changing. Reset-held data registers are shown to contribute zero.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
  typedef struct packed {
    logic accum;
    logic frac;
  } mac_ctrl_t;
endpackage

// File: rtl/mac4_lane.sv
module mac4_lane #(
  parameter int DATA_W = 10,
  parameter int COEF_W = 11,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic                     en_i,
  input  logic                     sel_coef_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [DATA_W-1:0] data_q;
  logic signed [COEF_W-1:0] coef_q;
  logic                     data_ld, coef_ld;

  // enable steers to one operand; the other loads every clock
  assign data_ld = sel_coef_i ? 1'b1 : en_i;
  assign coef_ld = sel_coef_i ? en_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      coef_q <= '0;
      prod_o <= '0;
    end else begin
      if (data_ld) data_q <= data_i;
      if (coef_ld) coef_q <= coef_i;
      prod_o <= data_q * coef_q;
    end
  end

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_coef_i && !en_i) |=> $stable(data_q)); // R4
  AST_COEF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_coef_i && !en_i) |=> $stable(coef_q)); // R4
endmodule

// File: rtl/mac4_sum.sv
module mac4_sum #(
  parameter int LANES  = 4,
  parameter int PROD_W = 21,
  localparam int SUM_W = PROD_W + $clog2(LANES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LANES*PROD_W-1:0]  prod_i,
  output logic signed [SUM_W-1:0]  sum_o
);
  logic signed [PROD_W-1:0] prod_a [LANES];
  logic signed [SUM_W-1:0]  total;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign prod_a[g] = prod_i[g*PROD_W +: PROD_W];
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total = total + SUM_W'(prod_a[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= total;
  end
endmodule

// File: rtl/mac4_acc.sv
module mac4_acc
  import mac4_pkg::*;
#(
  parameter int SUM_W = 23,
  parameter int ACC_W = 25,
  parameter int OUT_W = 16,
  localparam int FRAC_SHIFT = ACC_W - OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SUM_W-1:0] sum_i,
  input  mac_ctrl_t               ctrl_i,
  output logic [ACC_W-1:0]        acc_o
);
  localparam logic [ACC_W-1:0] RND = ACC_W'(1) << (FRAC_SHIFT - 1);

  logic [ACC_W-1:0] sum_ext;
  assign sum_ext = ACC_W'(sum_i);

  // rounding enters only on a fresh load, so it counts once per run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_o <= '0;
    else if (ctrl_i.accum) acc_o <= acc_o + sum_ext;
    else if (ctrl_i.frac)  acc_o <= sum_ext + RND;
    else                   acc_o <= sum_ext;
  end
endmodule

// File: rtl/mac4_array.sv
module mac4_array
  import mac4_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 10,
  parameter int COEF_W = 11,
  parameter int ACC_W  = 25,
  parameter int OUT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES*DATA_W-1:0] data_i,
  input  logic [LANES*COEF_W-1:0] coef_i,
  input  logic [LANES-1:0]        lane_en_i,
  input  logic                    sel_coef_i,
  input  logic                    accum_i,
  input  logic                    frac_i,
  input  logic                    out_en_i,
  output logic [OUT_W-1:0]        sum_o
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + $clog2(LANES);
  localparam int CTRL_STAGES = 3;

  logic [LANES*PROD_W-1:0] prod_flat;
  logic signed [SUM_W-1:0] sum_w;
  logic [ACC_W-1:0]        acc_w;
  mac_ctrl_t               ctrl_q [CTRL_STAGES];
  logic                    frac_q4;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [PROD_W-1:0] prod;
    mac4_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .data_i     (data_i[g*DATA_W +: DATA_W]),
      .coef_i     (coef_i[g*COEF_W +: COEF_W]),
      .en_i       (lane_en_i[g]),
      .sel_coef_i (sel_coef_i),
      .prod_o     (prod)
    );
    assign prod_flat[g*PROD_W +: PROD_W] = prod;
  end

  mac4_sum #(.LANES(LANES), .PROD_W(PROD_W)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prod_i (prod_flat),
    .sum_o  (sum_w)
  );

  // controls travel with their operands: in, product, sum stages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CTRL_STAGES; i++) ctrl_q[i] <= '0;
      frac_q4 <= 1'b0;
    end else begin
      ctrl_q[0] <= '{accum: accum_i, frac: frac_i};
      for (int i = 1; i < CTRL_STAGES; i++) ctrl_q[i] <= ctrl_q[i-1];
      frac_q4 <= ctrl_q[CTRL_STAGES-1].frac;
    end
  end

  mac4_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sum_i  (sum_w),
    .ctrl_i (ctrl_q[CTRL_STAGES-1]),
    .acc_o  (acc_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sum_o <= '0;
    else if (out_en_i) sum_o <= frac_q4 ? acc_w[ACC_W-1 -: OUT_W] : acc_w[OUT_W-1:0];
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> $stable(sum_o)); // R9
  AST_INT_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && !frac_q4) |=> (sum_o == $past(acc_w[OUT_W-1:0]))); // R6
  AST_FRAC_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && frac_q4) |=> (sum_o == $past(acc_w[ACC_W-1 -: OUT_W]))); // R7
endmodule

// File: tb/mac4_array_bench.sv
module mac4_array_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] data_i = '0;
  logic [43:0] coef_i = '0;
  logic [3:0]  lane_en_i = '0;
  logic        sel_coef_i = 1'b0;
  logic        accum_i = 1'b0;
  logic        frac_i = 1'b0;
  logic        out_en_i = 1'b1;
  logic [15:0] sum_o;

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    chk_on = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mac4_array u_mac4_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .coef_i(coef_i),
    .lane_en_i(lane_en_i), .sel_coef_i(sel_coef_i), .accum_i(accum_i),
    .frac_i(frac_i), .out_en_i(out_en_i), .sum_o(sum_o)
  );

  // behavioural reference: held operands, running total, 4-deep output queue
  logic signed [9:0]  m_d [4];
  logic signed [10:0] m_c [4];
  logic [24:0]        m_acc;
  logic [15:0]        m_q [$];
  logic [15:0]        exp_o;
  int                 s;
  logic [15:0]        o_new, o_old;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) begin m_d[i] = '0; m_c[i] = '0; end
      m_acc = '0;
      m_q = '{16'h0, 16'h0, 16'h0, 16'h0};
      exp_o = '0;
    end else begin
      s = 0;
      for (int i = 0; i < 4; i++) begin
        if (sel_coef_i || lane_en_i[i])  m_d[i] = data_i[i*10 +: 10];
        if (!sel_coef_i || lane_en_i[i]) m_c[i] = coef_i[i*11 +: 11];
        s = s + int'(m_d[i]) * int'(m_c[i]);
      end
      if (accum_i)     m_acc = m_acc + 25'(s);
      else if (frac_i) m_acc = 25'(s) + 25'd256;
      else             m_acc = 25'(s);
      o_new = frac_i ? m_acc[24:9] : m_acc[15:0];
      m_q.push_back(o_new);
      o_old = m_q.pop_front();
      if (out_en_i) exp_o = o_old;
    end
  end

  always @(negedge clk_i) begin
    if (chk_on && rst_ni) begin
      n_vec++;
      if (sum_o !== exp_o) begin
        n_bad++;
        $display("FAIL %s: sum_o=%h expected %h at %0t", tag, sum_o, exp_o, $time);
      end
    end
  end

  task automatic rand_ops();
    for (int i = 0; i < 4; i++) begin
      data_i[i*10 +: 10] = 10'($urandom);
      coef_i[i*11 +: 11] = 11'($urandom);
    end
  endtask

  task automatic run(input string t, input int n, input int mode);
    tag = t;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      rand_ops();
      case (mode)
        0: begin lane_en_i = 4'hf; accum_i = 1'b0; frac_i = 1'b0; end              // R2 R6
        1: begin lane_en_i = 4'($urandom); sel_coef_i = 1'($urandom);
                 accum_i = 1'b0; frac_i = 1'($urandom); end                        // R4
        2: begin lane_en_i = 4'hf; accum_i = ($urandom % 4) != 0; frac_i = 1'b0; end // R5
        3: begin lane_en_i = 4'hf; accum_i = 1'($urandom); frac_i = 1'b1; end        // R7
        default: begin lane_en_i = 4'($urandom); accum_i = 1'($urandom);
                 frac_i = 1'($urandom); out_en_i = 1'($urandom); end               // R9
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (sum_o !== 16'h0) begin
      n_bad++;
      $display("FAIL R1: sum_o=%h expected 0000 in reset", sum_o);
    end
    chk_on = 1'b1;
    rst_ni = 1'b1;
    // R1: data registers stay at reset zero while coefficients churn
    tag = "R1";
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      data_i = 40'($urandom) ^ {8'($urandom), 32'($urandom)};
      coef_i = {12'($urandom), 32'($urandom)};
      lane_en_i = 4'h0; sel_coef_i = 1'b0;
    end
    // R3: single-cycle impulse on lane 2
    tag = "R3";
    @(negedge clk_i);
    data_i = '0; coef_i = '0; lane_en_i = 4'hf; accum_i = 1'b0; frac_i = 1'b0;
    repeat (6) @(negedge clk_i);
    data_i[20 +: 10] = 10'sd37; coef_i[22 +: 11] = -11'sd5;
    @(negedge clk_i);
    data_i = '0;
    repeat (8) @(negedge clk_i);
    run("R2 R6", 300, 0);
    run("R4", 400, 1);
    sel_coef_i = 1'b0;
    run("R5", 300, 2);
    run("R7", 400, 3);
    // R8: largest positive products accumulated until the 25-bit total wraps
    tag = "R8";
    @(negedge clk_i);
    lane_en_i = 4'hf; frac_i = 1'b1; accum_i = 1'b0;
    data_i = {4{10'h200}}; coef_i = {4{11'h400}};
    for (int k = 0; k < 24; k++) begin
      @(negedge clk_i);
      accum_i = 1'b1;
    end
    @(negedge clk_i);
    frac_i = 1'b0;
    repeat (12) @(negedge clk_i);
    run("R9", 300, 4);
    out_en_i = 1'b1;
    repeat (8) @(negedge clk_i);
    chk_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule